// File: doc/BRIEF.md
# Integer Compare and Byte-Match Unit

This block is a purely combinational helper for a 32-bit integer datapath. It takes two operands, a carry input and a 2-bit operation select, and in the same cycle produces a 32-bit result for one of four operations.

The two compare operations form the difference "second operand minus first operand". When the operand signs differ, the top bit of the result is rewritten so that it reports the ordering. The signed compare takes that bit from the second operand, and the unsigned compare takes it from the first. The carry operation reports the carry out of the three-input sum of both operands and the carry input. The byte-match operation walks the byte lanes from the most significant lane downward and reports the 1-based position of the first lane where both operands hold the same byte, or zero when no lane matches.

The surrounding datapath consumes the result directly. Flags, writeback and pipeline control belong to the surrounding datapath.

Top module: `cmp_match_unit`

## Requirements
- R1: For the signed compare (op 00) and the unsigned compare (op 01), bits 30:0 of the result always equal bits 30:0 of (b - a), where a is `opnd_a` and b is `opnd_b`. When bit 31 of a equals bit 31 of b, the full 32-bit result equals (b - a) modulo 2^32.
- R2: For the signed compare (op 00), when bit 31 of a differs from bit 31 of b, bit 31 of the result equals bit 31 of b.
- R3: For the unsigned compare (op 01), when bit 31 of a differs from bit 31 of b, bit 31 of the result equals bit 31 of a.
- R4: The operation select is decoded as follows: 00 is the signed compare, 01 the unsigned compare, 10 the carry operation and 11 the byte match.
- R5: For the carry operation (op 10), bit 0 of the result is the carry out of a + b + carry_in computed over 33 bits, and bits 31:1 are zero.
- R6: For the byte match (op 11), lanes are numbered 1 for bits 31:24, 2 for bits 23:16, 3 for bits 15:8 and 4 for bits 7:0. The result is the number of the lowest-numbered lane whose bytes are equal in a and b, held in the low bits, with all upper bits zero.
- R7: For the byte match (op 11), the result is 0 when no lane holds equal bytes.
- R8: The result is a function of the present inputs only, with no clock and no state. `carry_in` has no effect on the result for ops 00, 01 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Operation select (00 signed compare, 01 unsigned compare, 10 carry, 11 byte match) |
| opnd_a | input | 32 | First operand a |
| opnd_b | input | 32 | Second operand b |
| carry_in | input | 1 | Carry input, used only by the carry operation |
| result | output | 32 | Result of the selected operation |

## Verification
The hardest case to reach is the sign-disagreement path of the compares. There the raw difference has overflowed and only the rewritten top bit carries the true ordering. Random operands reach it only half the time, and seldom at the extremes. The stimulus therefore pairs the values 0, all-ones, 0x80000000 and 0x7FFFFFFF against each other under both compare codes. The byte match gets operands built so that several lanes match at once, which exposes a wrong scan order. The carry operation gets operands placed exactly at the wrap point, with carry_in both clear and set.

// File: rtl/cmp_match_pkg.sv
package cmp_match_pkg;
  typedef enum logic [1:0] {
    OP_CMP_S  = 2'b00,
    OP_CMP_U  = 2'b01,
    OP_CARRY  = 2'b10,
    OP_BFIND  = 2'b11
  } cm_op_e;
endpackage

// File: rtl/cm_compare.sv
module cm_compare #(
  parameter int W         = 32,
  parameter bit IS_SIGNED = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] diff_out
);
  logic [W-1:0] raw;
  logic         top_src;

  // Two's complement difference b - a, written as b + ~a + 1
  assign raw = b + ~a + {{(W-1){1'b0}}, 1'b1};

  generate
    if (IS_SIGNED) begin : g_sgn
      assign top_src = b[W-1];
    end else begin : g_uns
      assign top_src = a[W-1];
    end
  endgenerate

  always_comb begin
    diff_out = raw;
    if (a[W-1] != b[W-1]) begin
      diff_out[W-1] = top_src;
    end
  end
endmodule

// File: rtl/cm_carry.sv
module cm_carry #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic         cout
);
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] room;
  logic [W-1:0] b_plus;

  // Headroom left above a, compared with the addend b + cin
  assign room   = ONES - a;
  assign b_plus = b + {{(W-1){1'b0}}, cin};

  always_comb begin
    if ((b == ONES) && cin) begin
      cout = 1'b1;
    end else begin
      cout = (room < b_plus);
    end
  end
endmodule

// File: rtl/cm_byte_find.sv
module cm_byte_find #(
  parameter int W      = 32,
  parameter int LANE_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [IDX_W-1:0] idx
);
  localparam int LANES = W / LANE_W;

  // hit[k] is for lane number k+1, counted from the most significant lane
  logic [LANES-1:0] hit;

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane
      localparam int HI = W - 1 - gl * LANE_W;
      assign hit[gl] = (a[HI -: LANE_W] == b[HI -: LANE_W]);
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (hit[k]) begin
        idx = IDX_W'(k + 1);
      end
    end
  end
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
  import cmp_match_pkg::*;
#(
  parameter int W      = 32,
  parameter int LANE_W = 8
) (
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         carry_in,
  output logic [W-1:0] result
);
  localparam int LANES = W / LANE_W;
  localparam int IDX_W = $clog2(LANES + 1);

  logic [W-1:0]     cmp_s;
  logic [W-1:0]     cmp_u;
  logic             cy;
  logic [IDX_W-1:0] lane_idx;

  cm_compare #(.W(W), .IS_SIGNED(1'b1)) u_cmp_s (
    .a        (opnd_a),
    .b        (opnd_b),
    .diff_out (cmp_s)
  );

  cm_compare #(.W(W), .IS_SIGNED(1'b0)) u_cmp_u (
    .a        (opnd_a),
    .b        (opnd_b),
    .diff_out (cmp_u)
  );

  cm_carry #(.W(W)) u_carry (
    .a    (opnd_a),
    .b    (opnd_b),
    .cin  (carry_in),
    .cout (cy)
  );

  cm_byte_find #(.W(W), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_find (
    .a   (opnd_a),
    .b   (opnd_b),
    .idx (lane_idx)
  );

  always_comb begin
    unique case (cm_op_e'(op_sel))
      OP_CMP_S: result = cmp_s;
      OP_CMP_U: result = cmp_u;
      OP_CARRY: result = {{(W-1){1'b0}}, cy};
      default:  result = {{(W-IDX_W){1'b0}}, lane_idx};
    endcase
  end
endmodule

// File: rtl/cmp_match_chk.sv
module cmp_match_chk #(
  parameter int W      = 32,
  parameter int LANE_W = 8
) (
  input logic [1:0]   op_sel,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         carry_in,
  input logic [W-1:0] result
);
  localparam int LANES = W / LANE_W;

  logic [W-1:0] sub_ref;
  assign sub_ref = opnd_b - opnd_a;

  always_comb begin
    if (!$isunknown({op_sel, opnd_a, opnd_b, carry_in})) begin
      // R1: the low bits of either compare follow the plain difference
      if (op_sel[1] == 1'b0) begin
        assert_cmp_low_R1: assert (result[W-2:0] == sub_ref[W-2:0])
          else $error("assert_cmp_low_R1");
      end
      // R2: the signed compare takes its top bit from b on sign disagreement
      if (op_sel == 2'b00 && opnd_a[W-1] != opnd_b[W-1]) begin
        assert_sgn_top_R2: assert (result[W-1] == opnd_b[W-1])
          else $error("assert_sgn_top_R2");
      end
      // R3: the unsigned compare takes its top bit from a on sign disagreement
      if (op_sel == 2'b01 && opnd_a[W-1] != opnd_b[W-1]) begin
        assert_uns_top_R3: assert (result[W-1] == opnd_a[W-1])
          else $error("assert_uns_top_R3");
      end
      // R5: the carry result is a single bit
      if (op_sel == 2'b10) begin
        assert_carry_bit_R5: assert (result[W-1:1] == '0)
          else $error("assert_carry_bit_R5");
      end
      // R6: a lane index never exceeds the lane count
      if (op_sel == 2'b11) begin
        assert_idx_range_R6: assert (result <= W'(LANES))
          else $error("assert_idx_range_R6");
      end
      // R6: identical operands always match in the first lane
      if (op_sel == 2'b11 && opnd_a == opnd_b) begin
        assert_first_lane_R6: assert (result == W'(1))
          else $error("assert_first_lane_R6");
      end
    end
  end
endmodule

bind cmp_match_unit cmp_match_chk #(.W(W), .LANE_W(LANE_W)) u_chk (
  .op_sel   (op_sel),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .carry_in (carry_in),
  .result   (result)
);

// File: tb/tb_cmp_match_unit.sv
module tb_cmp_match_unit;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [1:0]   op_sel;
  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  logic         carry_in;
  logic [W-1:0] result;

  int n_chk;
  int n_bad;

  cmp_match_unit dut (
    .op_sel   (op_sel),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .carry_in (carry_in),
    .result   (result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  // Vector layout: {op[1:0], a[31:0], b[31:0], cin, expected[31:0]}
  localparam int NV = 14;
  localparam logic [98:0] VEC [NV] = '{
    {2'b00, 32'h0000_0001, 32'h0000_0002, 1'b0, 32'h0000_0001},
    {2'b00, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 32'h7FFF_FFFF},
    {2'b01, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 32'hFFFF_FFFF},
    {2'b00, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 32'h8000_0001},
    {2'b01, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 32'h0000_0001},
    {2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000},
    {2'b01, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 32'h7FFF_FFFF},
    {2'b10, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0001},
    {2'b10, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000},
    {2'b10, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 32'h0000_0001},
    {2'b11, 32'h1122_3344, 32'h9922_3344, 1'b0, 32'h0000_0002},
    {2'b11, 32'h1122_3344, 32'h1100_0000, 1'b0, 32'h0000_0001},
    {2'b11, 32'h0102_0304, 32'h1020_3040, 1'b0, 32'h0000_0000},
    {2'b11, 32'h0000_00AA, 32'hFF11_22AA, 1'b0, 32'h0000_0004}
  };

  function automatic logic [W-1:0] ref_model(input logic [1:0] op,
                                              input logic [W-1:0] a,
                                              input logic [W-1:0] b,
                                              input logic c);
    logic [W-1:0] d;
    logic [W:0]   s;
    d = b - a;
    case (op)
      2'b00: return (a[W-1] != b[W-1]) ? {b[W-1], d[W-2:0]} : d;
      2'b01: return (a[W-1] != b[W-1]) ? {a[W-1], d[W-2:0]} : d;
      2'b10: begin
        s = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
        return {{(W-1){1'b0}}, s[W]};
      end
      default: begin
        for (int k = 0; k < 4; k++) begin
          if (a[31-8*k -: 8] == b[31-8*k -: 8]) return W'(k + 1);
        end
        return '0;
      end
    endcase
  endfunction

  task automatic apply(input logic [1:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic c);
    @(posedge clk);
    #1;
    op_sel = op; opnd_a = a; opnd_b = b; carry_in = c;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] exp_v);
    n_chk++;
    if (result !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%b a=%h b=%h cin=%b actual=%h expected=%h",
               req, op_sel, opnd_a, opnd_b, carry_in, result, exp_v);
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    logic [W-1:0] corner [4];
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    op_sel = 2'b00; opnd_a = '0; opnd_b = '0; carry_in = 1'b0;
    corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF;
    corner[2] = 32'h8000_0000; corner[3] = 32'h7FFF_FFFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R8: zero operands give a zero compare result right after start-up
    check("R8 startup", 32'h0);

    // Hand-computed vectors, covering R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][98:97], VEC[i][96:65], VEC[i][64:33], VEC[i][32]);
      case (VEC[i][98:97])
        2'b00:   check("R2/R1 R4 signed vector", VEC[i][31:0]);
        2'b01:   check("R3/R1 R4 unsigned vector", VEC[i][31:0]);
        2'b10:   check("R5 R4 carry vector", VEC[i][31:0]);
        default: check("R6/R7 R4 byte vector", VEC[i][31:0]);
      endcase
    end

    // Sign-boundary corners under every operation
    for (int op = 0; op < 4; op++) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          for (int c = 0; c < 2; c++) begin
            apply(2'(op), corner[i], corner[j], 1'(c));
            check("R1 R2 R3 R5 R6 R7 corner", ref_model(2'(op), corner[i], corner[j], 1'(c)));
          end
        end
      end
    end

    // Random operands, some with forced lane matches
    for (int n = 0; n < 2000; n++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      logic [1:0]   rop;
      ra  = $urandom;
      rb  = $urandom;
      rop = 2'($urandom_range(0, 3));
      if (n % 3 == 0) rb[15:8] = ra[15:8];
      if (n % 5 == 0) rb[31:24] = ra[31:24];
      apply(rop, ra, rb, 1'($urandom_range(0, 1)));
      check("R1 R2 R3 R5 R6 R7 random", ref_model(rop, ra, rb, carry_in));
    end

    // R8: carry_in must not affect the result for ops 00, 01 and 11
    for (int op = 0; op < 4; op++) begin
      if (op == 2) continue;
      apply(2'(op), 32'h8123_4567, 32'h0123_45FF, 1'b0);
      held = result;
      apply(2'(op), 32'h8123_4567, 32'h0123_45FF, 1'b1);
      check("R8 carry_in ignored", held);
    end

    // R6: a match in lane 3 only
    apply(2'b11, 32'hAABB_CCDD, 32'h0000_CC00, 1'b0);
    check("R6 lane3", 32'd3);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule